// File: doc/BRIEF.md
# Serial Divider-Programming Register

This block receives divider settings for a frequency synthesizer over a three-wire serial link made up of a data line, a shift clock and a load enable. Bits enter a 32-stage shift chain on each rising edge of the shift clock. The most recent bit always sits in stage 0 and acts as a routing flag. While the load enable is high, the swallow-count field (A) and the main-count field (N) are copied into their holding registers on every cycle. The reference-divider field (R) is copied only when the routing flag is 1. The last stage of the chain is driven straight out, so several of these registers can be chained on one data line.

All three serial inputs are asynchronous to the system clock. They pass through a synchronizer bank, and the shift clock is edge-detected in the system clock domain. The holding registers are level-enabled. They keep their values while the enable is low, and the enable is normally pulsed high once a word has been shifted in. A loaded value below the legal minimum of its counter is raised to that minimum.

Top module: `synth_serial_loader`

## Requirements
- R1: Each rising edge of `ser_clk` moves the chain up by one stage and places `ser_data` in stage 0. A word is sent most significant bit first, so after 32 edges word bit k sits in stage k.
- R2: Stage 0 is the routing flag. When it is 1 and `load_en` is high, `ref_div` takes chain bits 14:1.
- R3: While `load_en` is high, `a_cnt` takes chain bits 7:1 and `n_cnt` takes chain bits 17:8, whatever the routing flag holds.
- R4: When the routing flag is 0, a load pulse leaves `ref_div` unchanged.
- R5: While `load_en` is low, `ref_div`, `a_cnt` and `n_cnt` stay constant, even while bits are being shifted.
- R6: `ser_out` equals chain stage 31 at all times and is independent of `load_en`.
- R7: A reference field below 3 loads as 3. The largest field, 16383, loads unchanged.
- R8: An N field below 16 loads as 16. The largest field, 1023, loads unchanged.
- R9: After reset, `ref_div` is 3, `n_cnt` is 16, `a_cnt` is 0, and the chain, and therefore `ser_out`, is all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous; data shifts on its rising edge |
| ser_data | input | 1 | Serial data, asynchronous |
| load_en | input | 1 | Level load enable, asynchronous |
| ser_out | output | 1 | Last chain stage, for daisy-chaining |
| ref_div | output | 14 | Latched reference divide value |
| a_cnt | output | 7 | Latched swallow (A) count |
| n_cnt | output | 10 | Latched main (N) count |

## Verification
Directed words cover several cases:
- a routing flag of 1 against a routing flag of 0, which separates a full load from an A/N-only load;
- zero fields and all-ones fields, which expose the minimum clamps and the top of each range;
- a word shifted with no load pulse, which shows that the holding registers ignore shifting.

A second word is pushed behind the first, and `ser_out` is compared with each bit of the first word in turn. This checks bit order and the ungated output.

A seeded random phase mixes random words, random routing flags and skipped load pulses. A bench model predicts the three latched values after every step.

// File: rtl/synth_ld_pkg.sv
package synth_ld_pkg;

    // Default geometry of the programming word
    localparam int CHAIN_LEN   = 32;
    localparam int REF_WIDTH   = 14;
    localparam int SWAL_WIDTH  = 7;
    localparam int MAIN_WIDTH  = 10;
    localparam int REF_FLOOR   = 3;
    localparam int MAIN_FLOOR  = 16;

    // Position of the routing flag; the fields sit just above it
    localparam int FLAG_POS    = 0;

    // Highest field bit used, plus one
    function automatic int field_span(input int ref_w, input int swal_w, input int main_w);
        int r_top;
        int an_top;
        r_top  = FLAG_POS + 1 + ref_w;
        an_top = FLAG_POS + 1 + swal_w + main_w;
        return (r_top > an_top) ? r_top : an_top;
    endfunction

endpackage

// File: rtl/sync_bank.sv
module sync_bank #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] pipe;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_out = st_q.pipe[STAGES-1];

endmodule

// File: rtl/shift_chain.sv
module shift_chain #(
    parameter int LEN   = 32,
    parameter int OUT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_s,
    input  logic             din_s,
    output logic [OUT_W-1:0] low_bits,
    output logic             tail_bit
);

    typedef struct packed {
        logic [LEN-1:0] chain;
        logic           sclk_prev;
    } chain_state_t;

    chain_state_t st_d, st_q;
    logic         step;

    // Rising edge of the synchronized shift clock
    assign step = sclk_s & ~st_q.sclk_prev;

    always_comb begin
        st_d = st_q;
        st_d.sclk_prev = sclk_s;
        if (step) begin
            st_d.chain = {st_q.chain[LEN-2:0], din_s};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign low_bits = st_q.chain[OUT_W-1:0];
    assign tail_bit = st_q.chain[LEN-1];

    // R1: a detected edge moves every stage up by one and takes the new bit
    p_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (st_q.chain[0] == $past(din_s)) &&
                 (st_q.chain[LEN-1:1] == $past(st_q.chain[LEN-2:0])));

    // R1: with no edge the chain keeps its contents
    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(st_q.chain));

endmodule

// File: rtl/div_latches.sv
module div_latches #(
    parameter int IN_W       = 18,
    parameter int REF_W      = 14,
    parameter int SWAL_W     = 7,
    parameter int MAIN_W     = 10,
    parameter int REF_MIN    = 3,
    parameter int MAIN_MIN   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_s,
    input  logic [IN_W-1:0]   word,
    output logic [REF_W-1:0]  ref_val,
    output logic [SWAL_W-1:0] swal_val,
    output logic [MAIN_W-1:0] main_val
);
    import synth_ld_pkg::*;

    localparam int REF_LSB  = FLAG_POS + 1;
    localparam int SWAL_LSB = FLAG_POS + 1;
    localparam int MAIN_LSB = SWAL_LSB + SWAL_W;
    localparam logic [REF_W-1:0]  REF_LO  = REF_W'(REF_MIN);
    localparam logic [MAIN_W-1:0] MAIN_LO = MAIN_W'(MAIN_MIN);

    typedef struct packed {
        logic [REF_W-1:0]  ref_v;
        logic [SWAL_W-1:0] swal_v;
        logic [MAIN_W-1:0] main_v;
    } latch_state_t;

    latch_state_t      st_d, st_q;
    logic              route_ref;
    logic [REF_W-1:0]  ref_field;
    logic [MAIN_W-1:0] main_field;

    assign route_ref  = word[FLAG_POS];
    assign ref_field  = word[REF_LSB +: REF_W];
    assign main_field = word[MAIN_LSB +: MAIN_W];

    always_comb begin
        st_d = st_q;
        if (load_s) begin
            st_d.swal_v = word[SWAL_LSB +: SWAL_W];
            st_d.main_v = (main_field < MAIN_LO) ? MAIN_LO : main_field;
            if (route_ref) begin
                st_d.ref_v = (ref_field < REF_LO) ? REF_LO : ref_field;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ref_v  <= REF_LO;
            st_q.swal_v <= '0;
            st_q.main_v <= MAIN_LO;
        end else begin
            st_q <= st_d;
        end
    end

    assign ref_val  = st_q.ref_v;
    assign swal_val = st_q.swal_v;
    assign main_val = st_q.main_v;

    // R5: nothing moves while the enable is low
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load_s |=> $stable(st_q));

    // R4: a cleared routing flag protects the reference value
    p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_s && !route_ref) |=> $stable(st_q.ref_v));

    // R3: the swallow count follows its field during a load
    p_swal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_s |=> st_q.swal_v == $past(word[SWAL_LSB +: SWAL_W]));

    // R7: the reference value never drops below its floor
    p_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ref_v >= REF_LO);

    // R8: the main count never drops below its floor
    p_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.main_v >= MAIN_LO);

endmodule

// File: rtl/synth_serial_loader.sv
module synth_serial_loader #(
    parameter int CHAIN_W   = synth_ld_pkg::CHAIN_LEN,
    parameter int REF_W     = synth_ld_pkg::REF_WIDTH,
    parameter int SWAL_W    = synth_ld_pkg::SWAL_WIDTH,
    parameter int MAIN_W    = synth_ld_pkg::MAIN_WIDTH,
    parameter int REF_MIN   = synth_ld_pkg::REF_FLOOR,
    parameter int MAIN_MIN  = synth_ld_pkg::MAIN_FLOOR,
    parameter int SYNC_LVLS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              load_en,
    output logic              ser_out,
    output logic [REF_W-1:0]  ref_div,
    output logic [SWAL_W-1:0] a_cnt,
    output logic [MAIN_W-1:0] n_cnt
);
    import synth_ld_pkg::*;

    localparam int FIELD_W = field_span(REF_W, SWAL_W, MAIN_W);

    logic [2:0]         raw_in;
    logic [2:0]         synced;
    logic [FIELD_W-1:0] field_bits;

    assign raw_in = {load_en, ser_data, ser_clk};

    sync_bank #(
        .WIDTH  (3),
        .STAGES (SYNC_LVLS)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_in),
        .sync_out (synced)
    );

    shift_chain #(
        .LEN   (CHAIN_W),
        .OUT_W (FIELD_W)
    ) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (synced[0]),
        .din_s    (synced[1]),
        .low_bits (field_bits),
        .tail_bit (ser_out)
    );

    div_latches #(
        .IN_W     (FIELD_W),
        .REF_W    (REF_W),
        .SWAL_W   (SWAL_W),
        .MAIN_W   (MAIN_W),
        .REF_MIN  (REF_MIN),
        .MAIN_MIN (MAIN_MIN)
    ) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_s   (synced[2]),
        .word     (field_bits),
        .ref_val  (ref_div),
        .swal_val (a_cnt),
        .main_val (n_cnt)
    );

endmodule

// File: tb/synth_serial_loader_bench.sv
module synth_serial_loader_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_data = 1'b0;
    logic        load_en = 1'b0;
    logic        ser_out;
    logic [13:0] ref_div;
    logic [6:0]  a_cnt;
    logic [9:0]  n_cnt;

    int checks = 0;
    int fails  = 0;
    logic [13:0] m_ref;
    logic [6:0]  m_a;
    logic [9:0]  m_n;

    always #4 clk = ~clk;

    synth_serial_loader u_synth_serial_loader (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .load_en(load_en), .ser_out(ser_out), .ref_div(ref_div),
        .a_cnt(a_cnt), .n_cnt(n_cnt)
    );

    function automatic logic [13:0] exp_ref(input logic [31:0] w);
        return (w[14:1] < 14'd3) ? 14'd3 : w[14:1];
    endfunction

    function automatic logic [9:0] exp_n(input logic [31:0] w);
        return (w[17:8] < 10'd16) ? 10'd16 : w[17:8];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bit(input logic b);
        ser_data = b;
        wait_clk(3);
        ser_clk = 1'b1;
        wait_clk(4);
        ser_clk = 1'b0;
        wait_clk(3);
    endtask

    task automatic send_word(input logic [31:0] w);
        for (int i = 31; i >= 0; i--) shift_bit(w[i]);
    endtask

    task automatic pulse_load(input logic [31:0] w);
        load_en = 1'b1;
        wait_clk(4);
        load_en = 1'b0;
        wait_clk(4);
        m_a = w[7:1];
        m_n = exp_n(w);
        if (w[0]) m_ref = exp_ref(w);
    endtask

    task automatic check_all(input string tag);
        check({tag, " ref"}, 32'(ref_div), 32'(m_ref));
        check({tag, " A"},   32'(a_cnt),   32'(m_a));
        check({tag, " N"},   32'(n_cnt),   32'(m_n));
    endtask

    function automatic logic [31:0] mk_word(input logic [9:0] n, input logic [6:0] a,
                                           input logic [13:0] r, input logic ctl);
        logic [31:0] w;
        w = '0;
        w[0] = ctl;
        if (ctl) w[14:1] = r;
        else     w[17:1] = {n, a};
        return w;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] w1;
        logic [31:0] w2;
        logic [31:0] w;
        void'($urandom(32'd20250611));
        m_ref = 14'd3; m_a = 7'd0; m_n = 10'd16;
        wait_clk(3);
        // R9: reset values
        check_all("R9");
        check("R9 ser_out", 32'(ser_out), 32'd0);
        rst_n = 1'b1;
        wait_clk(3);

        // R3: A/N load with flag 0; R4: ref untouched
        w = mk_word(10'd300, 7'd45, 14'd0, 1'b0);
        send_word(w); pulse_load(w);
        check_all("R3/R4 an-load");

        // R2: reference load; R3: A/N follow the same word's bits
        w = mk_word(10'd0, 7'd0, 14'd1000, 1'b1);
        send_word(w); pulse_load(w);
        check_all("R2 ref-load");

        // R7 and R8: floors and top of range
        w = mk_word(10'd0, 7'd0, 14'd0, 1'b1);
        send_word(w); pulse_load(w);
        check("R7 ref floor", 32'(ref_div), 32'd3);
        check("R8 n floor", 32'(n_cnt), 32'd16);
        w = mk_word(10'd0, 7'd0, 14'h3fff, 1'b1);
        send_word(w); pulse_load(w);
        check("R7 ref max", 32'(ref_div), 32'd16383);
        w = mk_word(10'h3ff, 7'h7f, 14'd0, 1'b0);
        send_word(w); pulse_load(w);
        check("R8 n max", 32'(n_cnt), 32'd1023);
        check("R3 a max", 32'(a_cnt), 32'd127);
        check("R4 ref kept", 32'(ref_div), 32'd16383);

        // R5: shift with no load pulse changes nothing
        w = mk_word(10'd77, 7'd5, 14'd0, 1'b0) | 32'h0000_0001;
        send_word(w);
        check_all("R5 no-load");

        // R6 and R1: ser_out walks through the first word, MSB first
        w1 = 32'hA5C3_1E97;
        w2 = 32'h3C0F_F0E1;
        send_word(w1);
        for (int i = 0; i < 32; i++) begin
            check($sformatf("R6/R1 ser_out bit %0d", 31 - i), 32'(ser_out), 32'(w1[31-i]));
            shift_bit(w2[31-i]);
        end
        check("R6 ser_out after w2", 32'(ser_out), 32'(w2[31]));
        pulse_load(w2);
        check_all("R6 load after chain");

        // Random mix
        for (int k = 0; k < 40; k++) begin
            w = $urandom;
            send_word(w);
            if (($urandom % 4) != 0) begin
                pulse_load(w);
                check_all("R2/R3/R4 random");
            end else begin
                check_all("R5 random skip");
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule